// File: doc/BRIEF.md
# Bitset Similarity Cardinality Engine

This block measures how much two bitsets overlap. Words from bitset A and bitset B arrive side by side, one 64-bit word of each per accepted beat. Bit k of a word marks element k of the range that word covers. For every beat the block counts the ones in A AND B and in A OR B, and it adds each count to its own running total. When the beat flagged as last has been accepted, a sequential divider forms the ratio of the two totals. That ratio is the Jaccard index, produced as an unsigned 16-bit fraction.

The input is a valid/ready stream. A beat transfers on a rising edge where `in_valid` and `in_ready` are both high. The source may hold `in_valid` low for any number of cycles between beats. The block applies back-pressure by holding `in_ready` low in three cases: before the first `start`, during the cycle `start` is asserted, and from the last beat until the ratio is ready. A beat offered while `in_ready` is low is not taken, and the source must keep it in place. The control pins `start`, `done` and `undef` are plain level signals with no handshake.

Both totals remain on the outputs until the next `start`. The ratio and its undefined flag remain until the next `done`.

Top module: `bitset_jaccard_engine`

## Requirements
- R1: A beat is taken only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while a stream is open, and it is low in any cycle where `start` is high.
- R2: When `start` is high and no division is running, both totals read 0 in the next cycle and a stream opens. When `start` is high while a division is running, it has no effect on the totals, on `in_ready` or on when `done` arrives.
- R3: `inter_cnt` is the sum, over all taken beats, of the number of ones in `in_a & in_b`. Bit k of each word is element k.
- R4: `union_cnt` is the sum, over all taken beats, of the number of ones in `in_a | in_b`.
- R5: Each taken beat appears in both totals in the cycle after the edge that takes it.
- R6: Taking a beat with `in_last` high closes the stream. `in_ready` is low from the next cycle until `done`.
- R7: `done` is a one-cycle pulse. It is high in the cycle after the 18th rising edge counted from the edge that took the last beat. After `done`, `in_ready` stays low until the next `start`.
- R8: When 0 < `inter_cnt` < `union_cnt`, `ratio` equals floor(`inter_cnt` * 65536 / `union_cnt`), read as a fraction with 16 fractional bits. When `inter_cnt` is 0 and `union_cnt` is not, `ratio` is 0.
- R9: When the two totals are equal and nonzero, `ratio` saturates to 16'hFFFF.
- R10: When `union_cnt` is 0, `ratio` is 0 and `undef` is high. Otherwise `undef` is low. Both outputs change only at `done` and hold their value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears both totals and opens a stream; ignored while a division runs |
| in_valid | input | 1 | Source offers a beat |
| in_ready | output | 1 | Engine can take a beat |
| in_a | input | 64 | Word from bitset A |
| in_b | input | 64 | Word from bitset B |
| in_last | input | 1 | The offered beat is the final one of the stream |
| done | output | 1 | One-cycle pulse: `ratio` and `undef` are updated |
| inter_cnt | output | 32 | Running intersection cardinality |
| union_cnt | output | 32 | Running union cardinality |
| ratio | output | 16 | Intersection over union, 16 fractional bits |
| undef | output | 1 | Union was empty, so the ratio is undefined |

## Verification
A fault in the popcount tree or in the accumulators shows up on `inter_cnt` or `union_cnt` one cycle after the beat that exposes it. The bench compares both totals after every taken beat, so such a fault is pinned to a single beat. A fault in the control state shows up at once as `in_ready` at the wrong level. Examples are a beat taken during a division, or a `start` that is honoured while a division runs. A fault in the divider stays hidden until `done`. It then appears as a wrong `ratio` or `undef`, or as `done` arriving on the wrong cycle, which the scoreboard checks to the exact cycle.

// File: rtl/jacc_pkg.sv
package jacc_pkg;
  // Control phases of the engine.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // no stream open, waiting for start
    ST_ACCUM = 2'd1,  // stream open, taking beats
    ST_DIV   = 2'd2   // last beat taken, ratio being formed
  } eng_state_e;
endpackage

// File: rtl/popcnt_tree.sv
// Counts the ones in a power-of-two wide vector with a balanced adder tree.
// Nodes are heap-indexed: leaves sit at W..2W-1, node i sums nodes 2i and 2i+1.
module popcnt_tree #(
  parameter int W = 64
) (
  input  logic [W-1:0]       vec,
  output logic [$clog2(W):0] cnt
);
  localparam int CW = $clog2(W) + 1;

  logic [CW-1:0] node [1:2*W-1];

  for (genvar i = 0; i < W; i++) begin : g_leaf
    assign node[W+i] = CW'(vec[i]);
  end

  for (genvar i = 1; i < W; i++) begin : g_sum
    assign node[i] = node[2*i] + node[2*i+1];
  end

  assign cnt = node[1];
endmodule

// File: rtl/pair_accum.sv
// Per-beat AND/OR popcounts and their running totals.
module pair_accum #(
  parameter int WORD_W = 64,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic [ACC_W-1:0]  inter_tot,
  output logic [ACC_W-1:0]  union_tot
);
  localparam int PW = $clog2(WORD_W) + 1;

  logic [PW-1:0] pc_and, pc_or;

  popcnt_tree #(.W(WORD_W)) u_pc_and (.vec(word_a & word_b), .cnt(pc_and));
  popcnt_tree #(.W(WORD_W)) u_pc_or  (.vec(word_a | word_b), .cnt(pc_or));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      inter_tot <= '0;
      union_tot <= '0;
    end else if (beat) begin
      inter_tot <= inter_tot + ACC_W'(pc_and);
      union_tot <= union_tot + ACC_W'(pc_or);
    end
  end
endmodule

// File: rtl/frac_divider.sv
// Restoring divider: one quotient bit per cycle, Q_W cycles in all.
// Produces floor(num * 2^Q_W / den) for num < den. When num >= den it
// saturates to all ones, and when den == 0 it gives 0 with undef set.
module frac_divider #(
  parameter int NUM_W = 32,
  parameter int Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] den,
  output logic             busy,
  output logic             fin,
  output logic [Q_W-1:0]   quot,
  output logic             undef
);
  localparam int CNT_W = $clog2(Q_W + 1);

  logic [NUM_W:0]   rem_q;
  logic [NUM_W-1:0] den_q;
  logic [Q_W-1:0]   q_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sat_q, zero_q;

  logic [NUM_W:0] trial;
  logic           fits;

  assign trial = rem_q << 1;
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      sat_q  <= 1'b0;
      zero_q <= 1'b0;
      busy   <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        rem_q  <= {1'b0, num};
        den_q  <= den;
        q_q    <= '0;
        cnt_q  <= CNT_W'(Q_W);
        sat_q  <= (den != '0) && (num >= den);
        zero_q <= (den == '0);
        busy   <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? (trial - {1'b0, den_q}) : trial;
        q_q   <= {q_q[Q_W-2:0], fits};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quot  = zero_q ? '0 : (sat_q ? '1 : q_q);
  assign undef = zero_q;
endmodule

// File: rtl/bitset_jaccard_engine.sv
module bitset_jaccard_engine
  import jacc_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int ACC_W  = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_last,
  output logic              done,
  output logic [ACC_W-1:0]  inter_cnt,
  output logic [ACC_W-1:0]  union_cnt,
  output logic [FRAC_W-1:0] ratio,
  output logic              undef
);
  eng_state_e state_q;

  logic              start_ok, beat, launch_q, dividing;
  logic              div_busy, div_fin, div_undef;
  logic [FRAC_W-1:0] div_quot;

  assign dividing = (state_q == ST_DIV);
  assign start_ok = start && !dividing;
  assign in_ready = (state_q == ST_ACCUM) && !start;
  assign beat     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      launch_q <= 1'b0;
    end else begin
      launch_q <= beat && in_last;
      unique case (state_q)
        ST_IDLE:  if (start_ok) state_q <= ST_ACCUM;
        ST_ACCUM: if (start_ok) state_q <= ST_ACCUM;
                  else if (beat && in_last) state_q <= ST_DIV;
        ST_DIV:   if (div_fin) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  pair_accum #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_ok),
    .beat      (beat),
    .word_a    (in_a),
    .word_b    (in_b),
    .inter_tot (inter_cnt),
    .union_tot (union_cnt)
  );

  frac_divider #(.NUM_W(ACC_W), .Q_W(FRAC_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (launch_q),
    .num   (inter_cnt),
    .den   (union_cnt),
    .busy  (div_busy),
    .fin   (div_fin),
    .quot  (div_quot),
    .undef (div_undef)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      ratio <= '0;
      undef <= 1'b0;
    end else begin
      done <= div_fin;
      if (div_fin) begin
        ratio <= div_quot;
        undef <= div_undef;
      end
    end
  end
endmodule

// File: rtl/jacc_checker.sv
module jacc_checker #(
  parameter int ACC_W = 32,
  parameter int Q_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             done,
  input logic [ACC_W-1:0] inter_cnt,
  input logic [ACC_W-1:0] union_cnt,
  input logic [Q_W-1:0]   ratio,
  input logic             undef,
  input logic             dividing
);
  assert_no_ready_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready);

  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dividing) |=> (inter_cnt == '0 && union_cnt == '0));

  assert_start_ignored_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dividing) |=> ($stable(inter_cnt) && $stable(union_cnt)));

  assert_inter_within_union_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inter_cnt <= union_cnt);

  assert_union_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((union_cnt - $past(union_cnt)) <= ACC_W'(64)));

  assert_totals_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !start) |=> ($stable(inter_cnt) && $stable(union_cnt)));

  assert_ready_drop_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_saturate_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !undef && inter_cnt == union_cnt) |-> (ratio == '1));

  assert_undef_zero_ratio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (ratio == '0));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ratio) && $stable(undef)));
endmodule

bind bitset_jaccard_engine jacc_checker #(.ACC_W(ACC_W), .Q_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .done      (done),
  .inter_cnt (inter_cnt),
  .union_cnt (union_cnt),
  .ratio     (ratio),
  .undef     (undef),
  .dividing  (dividing)
);

// File: tb/tb_bitset_jaccard_engine.sv
module tb_bitset_jaccard_engine;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        in_last = 1'b0;
  logic        done;
  logic [31:0] inter_cnt, union_cnt;
  logic [15:0] ratio;
  logic        undef;

  always #2.5 clk = ~clk;

  bitset_jaccard_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_a(in_a), .in_b(in_b), .in_last(in_last),
    .done(done), .inter_cnt(inter_cnt), .union_cnt(union_cnt),
    .ratio(ratio), .undef(undef)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int unsigned inter;
    int unsigned uni;
    logic [15:0] ratio;
    logic        undef;
    int unsigned due;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [63:0] wa[$];
  logic [63:0] wb[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Expected ratio from the requirements (R8, R9, R10).
  function automatic logic [15:0] model_ratio(input int unsigned i, input int unsigned u);
    longint unsigned q;
    if (u == 0) return 16'h0000;
    if (i >= u) return 16'hFFFF;
    q = (longint'(i) << 16) / longint'(u);
    return q[15:0];
  endfunction

  // Driver: plays wa/wb as one stream and pushes the expected result.
  task automatic send_stream(input bit gaps, input bit poke_start, input string tag);
    int unsigned si = 0, su = 0, e0 = 0;
    exp_t e;
    @(negedge clk);
    start = 1'b1; in_valid = 1'b1; in_a = '1; in_b = '1; in_last = 1'b0;
    #1 check(in_ready == 1'b0, "R1", "in_ready during start", in_ready, 0);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    check(inter_cnt == 0 && union_cnt == 0, "R2", "totals after start",
          union_cnt, 0);
    for (int k = 0; k < wa.size(); k++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        repeat (g) @(negedge clk);
      end
      in_valid = 1'b1; in_a = wa[k]; in_b = wb[k]; in_last = (k == wa.size() - 1);
      #1 check(in_ready == 1'b1, "R1", "in_ready while stream open", in_ready, 1);
      e0 = cyc + 1;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      si += $countones(wa[k] & wb[k]);
      su += $countones(wa[k] | wb[k]);
      check(inter_cnt == si, "R3", "intersection total", inter_cnt, si);
      check(union_cnt == su, "R4", "union total", union_cnt, su);
      check(cyc == e0, "R5", "update cycle", cyc, e0);
    end
    e.inter = si; e.uni = su; e.ratio = model_ratio(si, su);
    e.undef = (su == 0); e.due = e0 + 18; e.tag = tag;
    exp_q.push_back(e);
    check(in_ready == 1'b0, "R6", "in_ready after last", in_ready, 0);
    // A beat offered during the division must not be taken (R6).
    in_valid = 1'b1; in_a = '1; in_b = '1;
    @(negedge clk);
    in_valid = 1'b0;
    check(union_cnt == su, "R6", "offered beat ignored", union_cnt, su);
    if (poke_start) begin
      start = 1'b1;
      #1 check(in_ready == 1'b0, "R2", "in_ready with start while dividing", in_ready, 0);
      @(negedge clk);
      start = 1'b0;
      check(inter_cnt == si && union_cnt == su, "R2", "start ignored while dividing",
            inter_cnt, si);
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R7", "in_ready idle after done", in_ready, 0);
    check(done == 1'b0, "R7", "done is one cycle", done, 0);
  endtask

  // Monitor: pops the scoreboard whenever done is seen.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "done with nothing expected", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc == e.due, "R7", "done cycle", cyc, e.due);
        check(ratio == e.ratio, e.tag, "ratio", ratio, e.ratio);
        check(undef == e.undef, "R10", "undef", undef, e.undef);
        check(inter_cnt == e.inter && union_cnt == e.uni, "R3", "totals at done",
              inter_cnt, e.inter);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R1", "reset in_ready", in_ready, 0);
    check(done == 1'b0, "R7", "reset done", done, 0);
    check(inter_cnt == 0 && union_cnt == 0, "R2", "reset totals", union_cnt, 0);
    check(ratio == 0 && undef == 0, "R10", "reset ratio", ratio, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R1", "idle before start", in_ready, 0);

    // Single pair: AND has 2 ones, OR has 6 -> 21845 (R8).
    wa = '{64'hF0}; wb = '{64'hAA};
    send_stream(1'b0, 1'b0, "R8");

    // Element positions: bit 63 shared, bits 0 and 1 disjoint -> 1/3 (R3, R8).
    wa = '{64'h8000_0000_0000_0000, 64'h1};
    wb = '{64'h8000_0000_0000_0000, 64'h2};
    send_stream(1'b1, 1'b0, "R8");

    // Random stream with gaps and a start pulse during the division (R2, R8).
    wa.delete(); wb.delete();
    for (int k = 0; k < 24; k++) begin wa.push_back(rnd64()); wb.push_back(rnd64()); end
    send_stream(1'b1, 1'b1, "R8");

    // Empty union -> undefined (R10).
    wa = '{64'h0, 64'h0, 64'h0}; wb = '{64'h0, 64'h0, 64'h0};
    send_stream(1'b0, 1'b0, "R10");

    // Identical sets -> saturation (R9).
    wa.delete(); wb.delete();
    for (int k = 0; k < 5; k++) begin
      logic [63:0] w = rnd64() | 64'h1;
      wa.push_back(w); wb.push_back(w);
    end
    send_stream(1'b1, 1'b0, "R9");

    // Full against empty: intersection 0, union 128 -> 0, defined (R8).
    wa = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF}; wb = '{64'h0, 64'h0};
    send_stream(1'b0, 1'b0, "R8");

    // All ones both sides -> saturation (R9).
    wa = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};
    wb = wa;
    send_stream(1'b0, 1'b1, "R9");

    // Sparse dense-driven stream, low overlap (R8).
    wa.delete(); wb.delete();
    for (int k = 0; k < 40; k++) begin
      wa.push_back(rnd64() & rnd64()); wb.push_back(rnd64() & rnd64() & rnd64());
    end
    send_stream(1'b0, 1'b0, "R8");

    summary();
    $finish;
  end
endmodule